// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level tree of 32-bit entries kept in memory. The root of the tree is a directory base register loaded through its own write port. A request carries the linear address, a write flag and a user flag. The block answers each request with one response: either a physical address or a fault.

On a fault, the faulting linear address goes into a fault-address register, and the response carries a three-bit reason code. While it walks, the block sets the accessed bit of each entry it uses. It also sets the dirty bit of the final entry on a write. Each of these updates is a read-modify-write on the memory port, and it is issued only when a bit actually changes.

A four-entry, fully associative translation cache holds recent page translations. The cache is keyed on the page number and refilled in round-robin order. Loading the directory base register invalidates the whole cache.

Top module: `page_walker`

## Requirements
- R1: A write to the directory base register stores the written value with bits 11..0 forced to zero; the stored value appears on `cr3` from the next cycle.
- R2: The directory entry is read at base + 4·LA[31:22]. The table entry is read at (directory entry bits 31..12, followed by 12 zero bits) + 4·LA[21:12]. The physical address is table entry bits 31..12 followed by LA[11:0].
- R3: An entry whose bit 0 (present) is clear ends the walk at once with a fault whose code bit 0 is 0. No further memory access follows. `cr2` then holds the request's linear address.
- R4: For a user request (`req_user`=1), bit 2 (user) must be set in both entries. For a user write, bit 1 (writable) must also be set in both entries. Otherwise the request faults with code bit 0 = 1, and the table entry is not modified.
- R5: For a supervisor request (`req_user`=0), bits 1 and 2 of the entries have no effect on the result.
- R6: Fault code bit 1 equals the request's write flag, and bit 2 equals its user flag.
- R7: Bit 5 (accessed) of each entry used is set by writing the entry back with bit 5 set. No write is issued when the bit is already set.
- R8: A successful write request leaves bit 6 (dirty) of the table entry set. When bits 5 and 6 both need setting, a single write-back sets both.
- R9: A request that hits the cache with sufficient rights responds in the cycle after acceptance, with no memory access.
- R10: A write request that hits a cache entry whose dirty bit is clear performs a full walk. A hit that lacks user rights also performs a full walk.
- R11: Writing the directory base register invalidates every cached translation.
- R12: Cache entries are replaced in round-robin order: after four fills with distinct pages, a fifth distinct page evicts the oldest of them.
- R13: `rsp_valid` is a one-cycle pulse. `req_ready` is low from acceptance until the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr3_wr | input | 1 | Load directory base register |
| cr3_din | input | 32 | Value to load |
| cr3 | output | 32 | Directory base register |
| cr2 | output | 32 | Linear address of the last fault |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_la | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_err | output | 3 | Fault code {user, write, protection} |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Updated entry |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry read |

## Verification
Timing is counted in clock edges from the accepting edge. A cache hit raises `rsp_valid` after that edge itself. A walk that makes n memory accesses raises it after 2n further edges, because the bench memory acknowledges one cycle after each request. Every scenario sums its expected reads and write-backs from the entry bits and compares the measured edge count against 2n+1. The bench samples 1 ns after each rising edge and counts completed accesses at the edges. The access pattern alone therefore separates a hit, a shortened walk and a walk with extra write-backs.

// File: rtl/page_walker.sv
module page_walker #(
  parameter int TLB_N = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cr3_wr,
  input  logic [31:0] cr3_din,
  output logic [31:0] cr3,
  output logic [31:0] cr2,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_la,
  input  logic        req_write,
  input  logic        req_user,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_pa,
  output logic [2:0]  rsp_err,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int IW = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  typedef enum logic [2:0] {S_IDLE, S_PDE_RD, S_PDE_WR, S_PTE_RD, S_PTE_WR, S_DONE} st_t;
  st_t st;

  logic [31:0] la_q, pde_q, pte_q;
  logic        wr_q, us_q, hit_q;
  logic [IW-1:0] hidx_q, rr_q;

  logic          tv [TLB_N];
  logic [19:0]   ttag [TLB_N];
  logic [19:0]   tfrm [TLB_N];
  logic          tu [TLB_N];
  logic          tw [TLB_N];
  logic          td [TLB_N];

  logic          hit;
  logic [IW-1:0] hidx;
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = 0; i < TLB_N; i++)
      if (tv[i] && ttag[i] == req_la[31:12]) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
  end

  wire hit_ok = hit && (!req_user || (tu[hidx] && (!req_write || tw[hidx])))
                    && (!req_write || td[hidx]);
  wire accept = req_valid && req_ready;

  wire [31:0] pde_addr = {cr3[31:12], la_q[31:22], 2'b00};
  wire [31:0] pte_addr = {pde_q[31:12], la_q[21:12], 2'b00};

  wire perm_ok = !us_q || (pde_q[2] && mem_rdata[2] && (!wr_q || (pde_q[1] && mem_rdata[1])));
  wire pte_upd = !mem_rdata[5] || (wr_q && !mem_rdata[6]);

  wire pde_ack = (st == S_PDE_RD) && mem_ack;
  wire pte_ack = (st == S_PTE_RD) && mem_ack;
  wire pde_np  = pde_ack && !mem_rdata[0];
  wire pte_bad = pte_ack && (!mem_rdata[0] || !perm_ok);
  wire fault_en = pde_np || pte_bad;
  wire fault_prot = pte_ack && mem_rdata[0];

  wire fill_en = (pte_ack && !pte_bad && !pte_upd) || ((st == S_PTE_WR) && mem_ack);
  wire [31:0] fill_pte = (st == S_PTE_RD) ? mem_rdata : mem_wdata;
  wire [IW-1:0] slot = hit_q ? hidx_q : rr_q;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign mem_req   = (st == S_PDE_RD) || (st == S_PDE_WR) || (st == S_PTE_RD) || (st == S_PTE_WR);
  assign mem_we    = (st == S_PDE_WR) || (st == S_PTE_WR);
  assign mem_addr  = ((st == S_PDE_RD) || (st == S_PDE_WR)) ? pde_addr : pte_addr;

  always_comb begin
    mem_wdata = 32'h0;
    if (st == S_PDE_WR)      mem_wdata = pde_q | 32'h20;
    else if (st == S_PTE_WR) mem_wdata = pte_q | 32'h20 | (wr_q ? 32'h40 : 32'h0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      la_q      <= '0;
      pde_q     <= '0;
      pte_q     <= '0;
      wr_q      <= 1'b0;
      us_q      <= 1'b0;
      hit_q     <= 1'b0;
      hidx_q    <= '0;
      rr_q      <= '0;
      cr3       <= '0;
      cr2       <= '0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_err   <= '0;
    end else begin
      if (cr3_wr) cr3 <= {cr3_din[31:12], 12'h000};
      case (st)
        S_IDLE: if (accept) begin
          la_q   <= req_la;
          wr_q   <= req_write;
          us_q   <= req_user;
          hit_q  <= hit;
          hidx_q <= hidx;
          if (hit_ok) begin
            rsp_fault <= 1'b0;
            rsp_err   <= '0;
            rsp_pa    <= {tfrm[hidx], req_la[11:0]};
            st        <= S_DONE;
          end else begin
            st <= S_PDE_RD;
          end
        end
        S_PDE_RD: if (mem_ack) begin
          pde_q <= mem_rdata;
          if (!mem_rdata[0])     st <= S_DONE;
          else if (!mem_rdata[5]) st <= S_PDE_WR;
          else                    st <= S_PTE_RD;
        end
        S_PDE_WR: if (mem_ack) begin
          pde_q <= mem_wdata;
          st    <= S_PTE_RD;
        end
        S_PTE_RD: if (mem_ack) begin
          pte_q <= mem_rdata;
          if (pte_bad)      st <= S_DONE;
          else if (pte_upd) st <= S_PTE_WR;
          else              st <= S_DONE;
        end
        S_PTE_WR: if (mem_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
      if (fault_en) begin
        cr2       <= la_q;
        rsp_fault <= 1'b1;
        rsp_pa    <= '0;
        rsp_err   <= {us_q, wr_q, fault_prot};
      end
      if (fill_en) begin
        rsp_fault <= 1'b0;
        rsp_err   <= '0;
        rsp_pa    <= {fill_pte[31:12], la_q[11:0]};
        if (!hit_q) rr_q <= (rr_q == IW'(TLB_N - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TLB_N; i++) tv[i] <= 1'b0;
    end else if (cr3_wr) begin
      for (int i = 0; i < TLB_N; i++) tv[i] <= 1'b0;
    end else if (fill_en) begin
      tv[slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      ttag[slot] <= la_q[31:12];
      tfrm[slot] <= fill_pte[31:12];
      tu[slot]   <= pde_q[2] & fill_pte[2];
      tw[slot]   <= pde_q[1] & fill_pte[1];
      td[slot]   <= fill_pte[6];
    end
  end
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_la,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [31:0] cr2,
  input logic [31:0] cr3,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata
);
  logic [31:0] la_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) la_seen <= '0;
    else if (req_valid && req_ready) la_seen <= req_la;
  end

  a_r1_base_aligned: assert property (@(posedge clk) disable iff (!rst_n) cr3[11:0] == 12'h000);
  a_r2_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_addr[1:0] == 2'b00);
  a_r3_fault_addr: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault) |-> cr2 == la_seen);
  a_r7_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> mem_wdata[5]);
  a_r13_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
  a_r13_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n) (mem_req || rsp_valid) |-> !req_ready);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind page_walker page_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_la(req_la),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .cr2(cr2), .cr3(cr3),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/page_walker_bench.sv
`timescale 1ns/100ps
module page_walker_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cr3_wr, req_valid, req_write, req_user, mem_ack;
  logic [31:0] cr3_din, req_la, mem_rdata;
  logic [31:0] cr3, cr2, rsp_pa, mem_addr, mem_wdata;
  logic        req_ready, rsp_valid, rsp_fault, mem_req, mem_we;
  logic [2:0]  rsp_err;

  page_walker u_page_walker (
    .clk(clk), .rst_n(rst_n), .cr3_wr(cr3_wr), .cr3_din(cr3_din), .cr3(cr3), .cr2(cr2),
    .req_valid(req_valid), .req_ready(req_ready), .req_la(req_la), .req_write(req_write),
    .req_user(req_user), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .rsp_err(rsp_err), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem [int unsigned];
  int n_acc, n_wr, n_cmp, n_bad;
  logic [31:0] first_addr;
  bit done;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= rd(mem_addr);
      if (mem_we) mem[mem_addr] = mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
    if (mem_req && mem_ack) begin
      if (n_acc == 0) first_addr = mem_addr;
      n_acc++;
      if (mem_we) n_wr++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] la, input bit w, input bit u, output int lat);
    @(negedge clk);
    req_la = la; req_write = w; req_user = u; req_valid = 1'b1;
    n_acc = 0; n_wr = 0; first_addr = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 100) begin
      @(posedge clk); #1;
      lat++;
    end
  endtask

  task automatic expect_ok(input string tag, input logic [31:0] la, input bit w, input bit u,
                           input logic [31:0] pa, input int nacc, input int nwr);
    int lat;
    do_req(la, w, u, lat);
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " fault"}, 32'(rsp_fault), 32'd0);
    check({tag, " pa"}, rsp_pa, pa);
    check({tag, " latency"}, lat, 2 * nacc + 1);
    check({tag, " accesses"}, n_acc, nacc);
    check({tag, " writebacks"}, n_wr, nwr);
    @(posedge clk); #1;
    check("R13 pulse ends", 32'(rsp_valid), 32'd0);
    check("R13 ready again", 32'(req_ready), 32'd1);
  endtask

  task automatic expect_fault(input string tag, input logic [31:0] la, input bit w, input bit u,
                              input logic [2:0] err, input int nacc);
    int lat;
    do_req(la, w, u, lat);
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check({tag, " fault"}, 32'(rsp_fault), 32'd1);
    check({tag, " code"}, 32'(rsp_err), 32'(err));
    check({tag, " cr2"}, cr2, la);
    check({tag, " accesses"}, n_acc, nacc);
    check({tag, " no writeback"}, n_wr, 0);
    check({tag, " latency"}, lat, 2 * nacc + 1);
    @(posedge clk); #1;
  endtask

  task automatic load_base(input logic [31:0] v);
    @(negedge clk); cr3_din = v; cr3_wr = 1'b1;
    @(negedge clk); cr3_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R13 reset ready", 32'(req_ready), 32'd1);
    check("R13 reset rsp", 32'(rsp_valid), 32'd0);
    check("R1 reset base", cr3, 32'h0);
    check("R3 reset cr2", cr2, 32'h0);
    check("R2 reset mem_req", 32'(mem_req), 32'd0);
  endtask

  task automatic t_base;
    load_base(32'h0001_0ABC);
    check("R1 low bits cleared", cr3, 32'h0001_0000);
  endtask

  task automatic t_first_walk;
    expect_ok("R2 R7 cold walk", 32'h0040_3123, 1'b0, 1'b0, 32'h0055_5123, 4, 2);
    check("R2 directory address", first_addr, 32'h0001_0004);
    check("R7 directory accessed", rd(32'h0001_0004), 32'h0002_0027);
    check("R7 table accessed", rd(32'h0002_000C), 32'h0055_5027);
  endtask

  task automatic t_hit;
    expect_ok("R9 hit", 32'h0040_3FFC, 1'b0, 1'b0, 32'h0055_5FFC, 0, 0);
  endtask

  task automatic t_dirty;
    expect_ok("R10 R8 write on clean", 32'h0040_3010, 1'b1, 1'b1, 32'h0055_5010, 3, 1);
    check("R8 dirty set", rd(32'h0002_000C), 32'h0055_5067);
    expect_ok("R9 write hit dirty", 32'h0040_3020, 1'b1, 1'b1, 32'h0055_5020, 0, 0);
  endtask

  task automatic t_not_present;
    expect_fault("R3 R6 dir absent", 32'h0080_0000, 1'b1, 1'b1, 3'b110, 1);
    expect_fault("R3 table absent", 32'h0040_5000, 1'b0, 1'b0, 3'b000, 2);
  endtask

  task automatic t_protect;
    expect_fault("R4 R6 user on supervisor page", 32'h0040_6010, 1'b0, 1'b1, 3'b101, 2);
    check("R4 entry untouched", rd(32'h0002_0018), 32'h0077_7001);
    expect_ok("R5 supervisor write", 32'h0040_6010, 1'b1, 1'b0, 32'h0077_7010, 3, 1);
    check("R8 R7 single writeback", rd(32'h0002_0018), 32'h0077_7061);
    expect_fault("R10 R4 hit lacking user", 32'h0040_6010, 1'b0, 1'b1, 3'b101, 2);
  endtask

  task automatic t_read_only;
    expect_ok("R4 user read", 32'h0040_7ABC, 1'b0, 1'b1, 32'h0088_8ABC, 2, 0);
    expect_fault("R4 R6 user write read-only", 32'h0040_7ABC, 1'b1, 1'b1, 3'b111, 2);
    check("R4 read-only untouched", rd(32'h0002_001C), 32'h0088_8025);
  endtask

  task automatic t_flush;
    load_base(32'h0001_0000);
    expect_ok("R11 walk after flush", 32'h0040_3000, 1'b0, 1'b0, 32'h0055_5000, 2, 0);
  endtask

  task automatic t_round_robin;
    expect_ok("R12 fill 2", 32'h0040_7000, 1'b0, 1'b0, 32'h0088_8000, 2, 0);
    expect_ok("R12 fill 3", 32'h0040_6000, 1'b0, 1'b0, 32'h0077_7000, 2, 0);
    expect_ok("R12 fill 4", 32'h0040_8000, 1'b0, 1'b0, 32'h0099_9000, 2, 0);
    expect_ok("R12 fill 5", 32'h0040_9000, 1'b0, 1'b0, 32'h00AA_A000, 2, 0);
    expect_ok("R12 survivor hits", 32'h0040_7004, 1'b0, 1'b0, 32'h0088_8004, 0, 0);
    expect_ok("R12 oldest evicted", 32'h0040_3008, 1'b0, 1'b0, 32'h0055_5008, 2, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    done = 1'b0; n_cmp = 0; n_bad = 0; n_acc = 0; n_wr = 0; first_addr = '0;
    rst_n = 1'b0; cr3_wr = 1'b0; cr3_din = '0; req_valid = 1'b0; req_la = '0;
    req_write = 1'b0; req_user = 1'b0; mem_ack = 1'b0; mem_rdata = '0;
    mem[32'h0001_0004] = 32'h0002_0007;
    mem[32'h0002_000C] = 32'h0055_5007;
    mem[32'h0002_0014] = 32'h0066_6006;
    mem[32'h0002_0018] = 32'h0077_7001;
    mem[32'h0002_001C] = 32'h0088_8025;
    mem[32'h0002_0020] = 32'h0099_9021;
    mem[32'h0002_0024] = 32'h00AA_A021;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset;
    t_base;
    t_first_walk;
    t_hit;
    t_dirty;
    t_not_present;
    t_protect;
    t_read_only;
    t_flush;
    t_round_robin;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule